// File: doc/BRIEF.md
# Sideways RAM Bank Probe Sequencer

This block is a small bus master that determines which of four paged memory banks can be written. The banks share one address window whose contents are chosen by a paging register on the same bus. After a start pulse, the sequencer reads and keeps the current paging value. It then takes each candidate bank in turn. For each bank it selects the bank, reads a test byte inside the window, writes back the bitwise inverse of that byte, reads it again, and then writes the original byte back. When all four banks are done it returns the paging register to the value it had at the start, publishes a 4-bit mask and pulses `done`.

Because the value written is the inverse of what was read, read-only memory cannot pass the test by chance. Because the original byte and the paging value are put back, software that was using the window sees no change. Every access is a request that waits for `busReady`, so memories of any latency are supported. Arbitration with other masters is outside this block.

Top module: `bankProbe`

## Requirements
- R1: After reset `busReq` and `done` are 0 and `ramMask` is 0.
- R2: The first access of a sequence is a read of the paging register at address 0xFE30. The last access writes that saved byte, all 8 bits, back to 0xFE30.
- R3: The banks are visited in ascending order 4, 5, 6, 7. Each is selected by writing its number (upper bits zero) to 0xFE30 before any access to its test byte.
- R4: For each bank the test byte at 0x803C is accessed as: read the original, write its bitwise inverse, read it back, write the original.
- R5: `ramMask` bit i (i = 0..3) is 1 exactly when the read-back byte of bank 4+i equals the inverse that was written to it.
- R6: `done` is a one-cycle pulse that follows the final paging write. `ramMask` changes only in the cycle where `done` is high and otherwise keeps its value, including during the next sequence.
- R7: A start pulse that arrives while a sequence is running has no effect: there are no extra accesses and no extra `done`.
- R8: While `busReq` is high and `busReady` is low, `busAddr`, `busWe` and `busWdata` stay constant. An access completes only in a cycle where `busReady` is high.
- R9: One sequence makes exactly 22 bus accesses, and `busReq` stays high from the first of them to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when idle |
| busReady | input | 1 | Current access completes this cycle |
| busRdata | input | 8 | Read data, valid when `busReady` is high |
| busReq | output | 1 | Access request |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | 16 | Access address |
| busWdata | output | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| ramMask | output | 4 | Bit i set when bank 4+i is writable |

## Verification
The bench runs every one of the 16 writable/read-only patterns over banks 4-7. These runs separate errors in bit position from errors in the comparison itself. Each pattern is run twice: once with zero-wait memory and once with a latency that changes from access to access. The slow runs expose handshake and hold faults, and they also carry a start pulse sent in the middle of a sequence. The starting paging value, including bit 7, and the test bytes (among them 0x00 and 0xFF) change from run to run. This shows whether the block restores the actual saved byte or some fixed value, and whether a read-only bank could match its own inverse.

// File: rtl/bankProbePkg.sv
package bankProbePkg;

  typedef enum logic [2:0] {
    OP_RD_PAGE,
    OP_WR_BANK,
    OP_RD_ORIG,
    OP_WR_INV,
    OP_RD_CHECK,
    OP_WR_ORIG,
    OP_WR_PAGE
  } busOpE;

  typedef struct packed {
    busOpE op;
    logic  active;
    logic  ack;
    logic  clrWork;
    logic  nextBank;
    logic  publish;
  } strobeT;

endpackage

// File: rtl/bankProbeCtrl.sv
module bankProbeCtrl
  import bankProbePkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   busReady,
  input  logic   lastBank,
  output strobeT stb,
  output logic   done
);

  typedef enum logic [3:0] {
    S_IDLE, S_SAVE, S_SEL, S_ORIG, S_INV, S_CHECK, S_RESTORE, S_PAGE, S_DONE
  } stateE;

  stateE state, nextState;

  always_comb begin
    nextState = state;
    stb = '0;
    stb.op = OP_RD_PAGE;
    case (state)
      S_IDLE: begin
        if (start) begin
          nextState = S_SAVE;
          stb.clrWork = 1'b1;
        end
      end
      S_SAVE: begin
        stb.active = 1'b1;
        stb.op = OP_RD_PAGE;
        if (busReady) nextState = S_SEL;
      end
      S_SEL: begin
        stb.active = 1'b1;
        stb.op = OP_WR_BANK;
        if (busReady) nextState = S_ORIG;
      end
      S_ORIG: begin
        stb.active = 1'b1;
        stb.op = OP_RD_ORIG;
        if (busReady) nextState = S_INV;
      end
      S_INV: begin
        stb.active = 1'b1;
        stb.op = OP_WR_INV;
        if (busReady) nextState = S_CHECK;
      end
      S_CHECK: begin
        stb.active = 1'b1;
        stb.op = OP_RD_CHECK;
        if (busReady) nextState = S_RESTORE;
      end
      S_RESTORE: begin
        stb.active = 1'b1;
        stb.op = OP_WR_ORIG;
        if (busReady) begin
          if (lastBank) begin
            nextState = S_PAGE;
          end else begin
            nextState = S_SEL;
            stb.nextBank = 1'b1;
          end
        end
      end
      S_PAGE: begin
        stb.active = 1'b1;
        stb.op = OP_WR_PAGE;
        if (busReady) begin
          nextState = S_DONE;
          stb.publish = 1'b1;
        end
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
    stb.ack = stb.active && busReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign done = (state == S_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE && state != S_SAVE) |=> (state != S_SAVE)); // R7

endmodule

// File: rtl/bankProbeDp.sv
module bankProbeDp
  import bankProbePkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int NUM_BANKS   = 4,
  parameter int FIRST_BANK  = 4,
  parameter logic [ADDR_W-1:0] PAGE_ADDR   = 16'hFE30,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'h8000,
  parameter int TEST_OFFSET = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWe,
  output logic [DATA_W-1:0] busWdata,
  output logic              lastBank,
  output logic [NUM_BANKS-1:0] ramMask
);

  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_BANKS - 1);
  localparam logic [DATA_W-1:0] FIRST_NUM = DATA_W'(FIRST_BANK);
  localparam logic [ADDR_W-1:0] TEST_ADDR = WINDOW_BASE + ADDR_W'(TEST_OFFSET);

  logic [DATA_W-1:0]    savedPage;
  logic [DATA_W-1:0]    origByte;
  logic [IDX_W-1:0]     bankIdx;
  logic [NUM_BANKS-1:0] work;
  logic [DATA_W-1:0]    bankNum;
  logic                 readMatch;

  assign bankNum   = FIRST_NUM + DATA_W'(bankIdx);
  assign lastBank  = (bankIdx == LAST_IDX);
  assign readMatch = (busRdata == ~origByte);

  always_comb begin
    busAddr  = TEST_ADDR;
    busWe    = 1'b0;
    busWdata = '0;
    case (stb.op)
      OP_RD_PAGE:  busAddr = PAGE_ADDR;
      OP_WR_BANK:  begin busAddr = PAGE_ADDR; busWe = 1'b1; busWdata = bankNum; end
      OP_RD_ORIG:  busAddr = TEST_ADDR;
      OP_WR_INV:   begin busWe = 1'b1; busWdata = ~origByte; end
      OP_RD_CHECK: busAddr = TEST_ADDR;
      OP_WR_ORIG:  begin busWe = 1'b1; busWdata = origByte; end
      OP_WR_PAGE:  begin busAddr = PAGE_ADDR; busWe = 1'b1; busWdata = savedPage; end
      default:     busAddr = TEST_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPage <= '0;
      origByte  <= '0;
      bankIdx   <= '0;
      ramMask   <= '0;
    end else begin
      if (stb.clrWork) bankIdx <= '0;
      else if (stb.nextBank) bankIdx <= bankIdx + 1'b1;
      if (stb.ack && stb.op == OP_RD_PAGE) savedPage <= busRdata;
      if (stb.ack && stb.op == OP_RD_ORIG) origByte <= busRdata;
      if (stb.publish) ramMask <= work;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gWork
    always_ff @(posedge clk) begin
      if (!rstN || stb.clrWork) work[g] <= 1'b0;
      else if (stb.ack && stb.op == OP_RD_CHECK && bankIdx == IDX_W'(g))
        work[g] <= readMatch;
    end
  end

  AST_MASK_ON_PUBLISH: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ramMask) |-> $past(stb.publish)); // R6

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.active && stb.op == OP_WR_BANK) |->
      (busWdata >= FIRST_NUM && busWdata < FIRST_NUM + DATA_W'(NUM_BANKS))); // R3

endmodule

// File: rtl/bankProbe.sv
module bankProbe
  import bankProbePkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int NUM_BANKS   = 4,
  parameter int FIRST_BANK  = 4,
  parameter logic [ADDR_W-1:0] PAGE_ADDR   = 16'hFE30,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'h8000,
  parameter int TEST_OFFSET = 8'h3C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 busReady,
  input  logic [DATA_W-1:0]    busRdata,
  output logic                 busReq,
  output logic                 busWe,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busWdata,
  output logic                 done,
  output logic [NUM_BANKS-1:0] ramMask
);

  strobeT stb;
  logic   lastBank;

  bankProbeCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .busReady (busReady),
    .lastBank (lastBank),
    .stb      (stb),
    .done     (done)
  );

  bankProbeDp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_BANKS   (NUM_BANKS),
    .FIRST_BANK  (FIRST_BANK),
    .PAGE_ADDR   (PAGE_ADDR),
    .WINDOW_BASE (WINDOW_BASE),
    .TEST_OFFSET (TEST_OFFSET)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .lastBank (lastBank),
    .ramMask  (ramMask)
  );

  assign busReq = stb.active;

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=>
      (busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata))); // R8

  AST_FIRST_IS_PAGE_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> (busAddr == PAGE_ADDR && !busWe)); // R2

  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq); // R6

endmodule

// File: tb/test_bankProbe.sv
module test_bankProbe;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       busReady;
  logic [7:0] busRdata;
  logic       busReq, busWe, done;
  logic [15:0] busAddr;
  logic [7:0] busWdata;
  logic [3:0] ramMask;

  always #10 clk = ~clk;

  bankProbe i_bankProbe (
    .clk(clk), .rstN(rstN), .start(start), .busReady(busReady),
    .busRdata(busRdata), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .done(done), .ramMask(ramMask)
  );

  // memory model configuration, written only by the stimulus
  logic [3:0] ramCfg = 4'h0;
  logic       latMode = 1'b0;
  logic       loadMem = 1'b0;
  logic [7:0] pgInit = 8'h00;
  logic [7:0] initByte [16];

  // memory model state
  logic [7:0] pg;
  logic [7:0] bankByte [16];
  int         waitCnt = 0;
  int         logN = 0;
  int         doneCnt = 0;
  int         stallErr = 0;
  logic [15:0] logAddr [1024];
  logic        logWe   [1024];
  logic [7:0]  logData [1024];

  int curLat;
  assign curLat = latMode ? (logN % 3) : 0;
  assign busReady = busReq && (waitCnt >= curLat);

  function automatic logic isRam(input logic [3:0] b, input logic [3:0] cfg);
    return (b >= 4'd4 && b <= 4'd7) ? cfg[b - 4'd4] : 1'b0;
  endfunction

  always_comb begin
    if (busAddr == 16'hFE30) busRdata = pg;
    else if (busAddr >= 16'h8000 && busAddr <= 16'hBFFF) busRdata = bankByte[pg[3:0]];
    else busRdata = 8'hEE;
  end

  always @(posedge clk) begin
    if (loadMem) begin
      pg <= pgInit;
      for (int b = 0; b < 16; b++) bankByte[b] <= initByte[b];
      waitCnt <= 0;
    end else if (busReq && busReady) begin
      waitCnt <= 0;
      if (logN < 1024) begin
        logAddr[logN] <= busAddr;
        logWe[logN]   <= busWe;
        logData[logN] <= busWdata;
      end
      logN <= logN + 1;
      if (busWe && busAddr == 16'hFE30) pg <= busWdata;
      else if (busWe && busAddr >= 16'h8000 && busAddr <= 16'hBFFF && isRam(pg[3:0], ramCfg))
        bankByte[pg[3:0]] <= busWdata;
    end else if (busReq) begin
      waitCnt <= waitCnt + 1;
    end
  end

  logic        prevStall = 1'b0;
  logic [15:0] pA;
  logic        pW;
  logic [7:0]  pD;
  always @(negedge clk) begin
    if (done) doneCnt <= doneCnt + 1;
    if (prevStall && (!busReq || busAddr != pA || busWe != pW || busWdata != pD))
      stallErr <= stallErr + 1;
    prevStall <= busReq && !busReady;
    pA <= busAddr; pW <= busWe; pD <= busWdata;
  end

  int total = 0;
  int failCnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [3:0] prevMask = 4'h0;

  task automatic runOne(input int cfg, input int mode);
    int logStart, doneStart, stallStart, t, bad, n;
    logic [7:0] orig [16];
    logic [15:0] eA;
    logic eW;
    logic [7:0] eD;
    ramCfg  = 4'(cfg);
    latMode = mode[0];
    pgInit  = {cfg[0] ^ mode[0], 3'b000, 4'(cfg ^ 9)};
    for (int b = 0; b < 16; b++) begin
      orig[b] = 8'(b * 29 + cfg * 7 + mode * 85);
      if (mode == 1 && b == 5) orig[b] = 8'hFF;
      if (mode == 1 && b == 6) orig[b] = 8'h00;
      initByte[b] = orig[b];
    end
    @(negedge clk) loadMem = 1'b1;
    @(negedge clk) loadMem = 1'b0;
    logStart = logN; doneStart = doneCnt; stallStart = stallErr;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (mode == 1) begin
      repeat (8) @(negedge clk);
      check(ramMask == prevMask, "R6", "mask held during next run", ramMask, prevMask);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(t < 2000, "R9", "sequence finished before timeout", t, 0);
    check(ramMask == 4'(cfg), "R5", "mask matches writable banks", ramMask, cfg);
    repeat (4) @(negedge clk);
    check(ramMask == 4'(cfg), "R6", "mask held after done", ramMask, cfg);
    check(doneCnt - doneStart == 1, "R7", "single done per run", doneCnt - doneStart, 1);
    n = logN - logStart;
    check(n == 22, "R9", "access count", n, 22);
    check(stallErr == stallStart, "R8", "signals held while stalled",
          stallErr - stallStart, 0);
    check(pg == pgInit, "R2", "paging value restored", pg, pgInit);
    bad = 0;
    for (int b = 4; b < 8; b++) if (bankByte[b] != orig[b]) bad++;
    check(bad == 0, "R4", "test bytes restored", bad, 0);
    if (n == 22 && logStart + 22 <= 1024) begin
      check(logAddr[logStart] == 16'hFE30 && !logWe[logStart], "R2", "first access reads page",
            logAddr[logStart], 16'hFE30);
      check(logAddr[logStart+21] == 16'hFE30 && logWe[logStart+21] &&
            logData[logStart+21] == pgInit, "R2", "last access writes saved page",
            logData[logStart+21], pgInit);
      bad = 0;
      for (int i = 0; i < 4; i++) begin
        int k = logStart + 1 + 5 * i;
        if (logAddr[k] != 16'hFE30 || !logWe[k] || logData[k] != 8'(4 + i)) bad++;
      end
      check(bad == 0, "R3", "ascending bank selects", bad, 0);
      bad = 0;
      for (int i = 0; i < 4; i++) begin
        for (int s = 1; s < 5; s++) begin
          int k = logStart + 1 + 5 * i + s;
          eA = 16'h803C;
          eW = (s == 2 || s == 4);
          eD = (s == 2) ? ~orig[4+i] : orig[4+i];
          if (logAddr[k] != eA || logWe[k] != eW || (eW && logData[k] != eD)) bad++;
        end
      end
      check(bad == 0, "R4", "test byte access pattern", bad, 0);
    end
    prevMask = 4'(cfg);
  endtask

  initial begin
    for (int b = 0; b < 16; b++) initByte[b] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busReq && !done && ramMask == 4'h0, "R1", "reset outputs",
          {busReq, done, ramMask}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busReq && !done && ramMask == 4'h0, "R1", "idle after reset",
          {busReq, done, ramMask}, 0);
    for (int mode = 0; mode < 2; mode++)
      for (int cfg = 0; cfg < 16; cfg++)
        runOne(cfg, mode);
    $display("%0d/%0d checks passed", total - failCnt, total);
    $finish;
  end

endmodule